// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a virtual address from the processor into a physical address by fetching one translation entry from a page table kept in main memory. The virtual address is divided into a page number (upper bits) and a byte offset within the page (lower bits). The page number indexes the table of the user that is currently running. That table is found through a table base register, which system software reloads when it switches users. The entry read from memory gives the physical page frame. The physical address is that frame followed by the unchanged offset. Pages of one program can therefore be placed anywhere in physical memory, and each user has a private mapping.

Every translation costs one memory read for the entry, ahead of the data access that the processor later makes with the result. The walker handles one translation at a time. The request, the memory read and the response each use a valid/ready handshake. A side holds its offer, with its payload unchanged, until the other side signals ready. The memory read port has a single outstanding read, and the read data comes back as a one-cycle pulse with no back-pressure. An entry whose valid bit is clear produces a fault response in place of an address.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.
- R2: A request is taken only when `req_valid` and `req_ready` are both 1 at a clock edge. From that edge until the edge where the response handshake completes, `req_ready` stays 0. It returns to 1 in the cycle after that handshake.
- R3: The entry read address is `tbase + (vaddr[VA_W-1:OFS_W] << 2)`. Entries are 4 bytes, and OFS_W is 12 by default.
- R4: Exactly one entry read is offered per translation. `mem_req_valid` rises in the cycle after the request is taken. It holds its address until the cycle in which `mem_req_ready` is 1, and then drops.
- R5: If bit 0 of the returned entry is 1, the response has `rsp_fault`=0 and `rsp_paddr = {entry[31:12], vaddr[11:0]}`.
- R6: If bit 0 of the returned entry is 0, the response has `rsp_fault`=1 and `rsp_paddr`=0.
- R7: `rsp_valid` rises in the cycle after `mem_rsp_valid` is sampled. The response then holds with the same payload until `rsp_ready` is 1.
- R8: A write to the table base (`tbase_we`) takes effect only while the walker is idle, that is, while `req_ready` is 1. A write in the same cycle as an accepted request applies to that request. A write made while a translation is in flight is dropped, and later translations keep using the old base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tbase_we | input | 1 | Load the table base register |
| tbase_wdata | input | PA_W | New table base |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | VA_W | Virtual address to translate |
| rsp_valid | output | 1 | Translation result offered |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | PA_W | Physical address (0 on fault) |
| rsp_fault | output | 1 | Entry was not valid |
| mem_req_valid | output | 1 | Entry read offered |
| mem_req_ready | input | 1 | Memory takes the read |
| mem_req_addr | output | PA_W | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data present (single-cycle pulse) |
| mem_rsp_data | input | PTE_W | Entry contents |

## Verification
The hardest case to reach is a table base write that arrives while a walk is in flight. It must be dropped, and the drop is only visible through the address of a later walk. The stimulus issues such writes while the entry read is stalled, then runs another translation and checks that its entry address still uses the old base. The directed cases also cover a base write in the same cycle as a request, stalls on both the read port and the response port, and entries forced valid and forced invalid at the extreme page numbers. These mix with seeded random addresses, bases and latencies.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_READ_PTE = 2'd1,
    ST_WAIT_PTE = 2'd2,
    ST_RESPOND  = 2'd3
  } ptw_state_e;

  localparam int unsigned ENTRY_BYTES = 4;
  localparam int unsigned PTE_VALID_BIT = 0;
endpackage

// File: rtl/ptw_tbase_reg.sv
module ptw_tbase_reg #(
  parameter int unsigned PA_W     = 32,
  parameter logic [PA_W-1:0] RST_VAL = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            idle,
  input  logic            we,
  input  logic [PA_W-1:0] wdata,
  output logic [PA_W-1:0] base
);
  // Writes while a walk is in flight are dropped so the entry address is stable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          base <= RST_VAL;
    else if (we && idle) base <= wdata;
  end
endmodule

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
  parameter int unsigned PA_W  = 32,
  parameter int unsigned VPN_W = 20
) (
  input  logic [PA_W-1:0]  base,
  input  logic [VPN_W-1:0] vpn,
  output logic [PA_W-1:0]  addr
);
  import ptw_pkg::*;
  localparam int unsigned SHIFT = $clog2(ENTRY_BYTES);

  logic [PA_W-1:0] index_bytes;

  generate
    if (PA_W > VPN_W + SHIFT) begin : g_wide
      assign index_bytes = {{(PA_W-VPN_W-SHIFT){1'b0}}, vpn, {SHIFT{1'b0}}};
    end else begin : g_narrow
      logic [VPN_W+SHIFT-1:0] full;
      assign full        = {vpn, {SHIFT{1'b0}}};
      assign index_bytes = full[PA_W-1:0];
    end
  endgenerate

  assign addr = base + index_bytes;
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm #(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned PFN_W = 20,
  parameter int unsigned PTE_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             idle,
  output logic [VA_W-1:0]  vaddr_q,
  output logic [PFN_W-1:0] pfn_q,
  output logic             pte_ok_q
);
  import ptw_pkg::*;

  ptw_state_e state, state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:     if (req_valid)     state_nx = ST_READ_PTE;
      ST_READ_PTE: if (mem_req_ready) state_nx = ST_WAIT_PTE;
      ST_WAIT_PTE: if (mem_rsp_valid) state_nx = ST_RESPOND;
      ST_RESPOND:  if (rsp_ready)     state_nx = ST_IDLE;
      default:                        state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vaddr_q <= '0;
    end else if (state == ST_IDLE && req_valid) begin
      vaddr_q <= req_vaddr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pfn_q    <= '0;
      pte_ok_q <= 1'b0;
    end else if (state == ST_WAIT_PTE && mem_rsp_valid) begin
      pfn_q    <= mem_rsp_data[PTE_W-1 -: PFN_W];
      pte_ok_q <= mem_rsp_data[PTE_VALID_BIT];
    end
  end

  assign idle          = (state == ST_IDLE);
  assign req_ready     = idle;
  assign mem_req_valid = (state == ST_READ_PTE);
  assign rsp_valid     = (state == ST_RESPOND);
endmodule

// File: rtl/ptw_result.sv
module ptw_result #(
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFS_W = 12
) (
  input  logic [PA_W-OFS_W-1:0] pfn,
  input  logic                  pte_ok,
  input  logic [OFS_W-1:0]      ofs,
  output logic [PA_W-1:0]       paddr,
  output logic                  fault
);
  assign fault = ~pte_ok;
  assign paddr = pte_ok ? {pfn, ofs} : '0;
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFS_W = 12,
  parameter int unsigned PTE_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tbase_we,
  input  logic [PA_W-1:0]  tbase_wdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_fault,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data
);
  localparam int unsigned VPN_W = VA_W - OFS_W;
  localparam int unsigned PFN_W = PA_W - OFS_W;

  logic             idle;
  logic [VA_W-1:0]  vaddr_q;
  logic [PFN_W-1:0] pfn_q;
  logic             pte_ok_q;
  logic [PA_W-1:0]  tbase;

  ptw_tbase_reg #(.PA_W(PA_W)) u_tbase (
    .clk(clk), .rst_n(rst_n), .idle(idle),
    .we(tbase_we), .wdata(tbase_wdata), .base(tbase)
  );

  ptw_fsm #(.VA_W(VA_W), .PFN_W(PFN_W), .PTE_W(PTE_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .idle(idle), .vaddr_q(vaddr_q), .pfn_q(pfn_q), .pte_ok_q(pte_ok_q)
  );

  ptw_entry_addr #(.PA_W(PA_W), .VPN_W(VPN_W)) u_eaddr (
    .base(tbase), .vpn(vaddr_q[VA_W-1:OFS_W]), .addr(mem_req_addr)
  );

  ptw_result #(.PA_W(PA_W), .OFS_W(OFS_W)) u_result (
    .pfn(pfn_q), .pte_ok(pte_ok_q), .ofs(vaddr_q[OFS_W-1:0]),
    .paddr(rsp_paddr), .fault(rsp_fault)
  );
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
  parameter int unsigned PA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            rsp_fault,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr
);
  p_busy_no_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_req_valid) |-> !req_ready);

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_read_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> mem_req_valid);

  p_read_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_read_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

  p_fault_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

  p_rsp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

  p_idle_after_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> req_ready);
endmodule

bind pt_walker ptw_checker #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
  .rsp_fault(rsp_fault), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr)
);

// File: tb/pt_walker_test.sv
module pt_walker_test;
  localparam int CLK_PERIOD = 10;
  localparam int VA_W = 32, PA_W = 32, OFS_W = 12, PTE_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tbase_we = 1'b0;
  logic [PA_W-1:0] tbase_wdata = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [VA_W-1:0] req_vaddr = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b0;
  logic [PA_W-1:0] rsp_paddr;
  logic rsp_fault;
  logic mem_req_valid;
  logic mem_req_ready = 1'b0;
  logic [PA_W-1:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [PTE_W-1:0] mem_rsp_data = '0;

  int tests = 0;
  int fails = 0;
  logic [PA_W-1:0] model_base = '0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker #(.VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W), .PTE_W(PTE_W)) uut (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // mode 0: hashed valid bit, 1: force valid, 2: force invalid
  function automatic logic [31:0] pte_fn(input logic [31:0] a, input int mode);
    logic [31:0] h;
    logic v;
    h = (a * 32'h9E3779B1) ^ 32'h5BD1E995;
    v = (mode == 1) ? 1'b1 : (mode == 2) ? 1'b0 : h[7];
    return {h[31:12], 11'h0, v};
  endfunction

  function automatic logic [31:0] entry_addr(input logic [31:0] base, input logic [31:0] va);
    return base + {va[31:12], 2'b00};
  endfunction

  task automatic set_base(input logic [31:0] b);
    @(negedge clk);
    tbase_we = 1'b1; tbase_wdata = b;
    @(negedge clk);
    tbase_we = 1'b0;
    model_base = b;
  endtask

  // wr_kind: 0 none, 1 base write while in flight (dropped), 2 base write with request
  task automatic translate(input logic [31:0] va, input int mode, input int wr_kind, input logic [31:0] wr_val);
    logic [31:0] exp_addr, pte, exp_pa;
    logic [31:0] held_addr, held_pa;
    logic held_f;
    int n;
    @(negedge clk);
    check(req_ready == 1'b1, "R2 idle before request", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_vaddr = va;
    if (wr_kind == 2) begin
      tbase_we = 1'b1; tbase_wdata = wr_val; model_base = wr_val;
    end
    @(negedge clk);
    req_valid = 1'b0; tbase_we = 1'b0;
    check(req_ready == 1'b0, "R2 busy after accept", 64'(req_ready), 64'd0);
    check(mem_req_valid == 1'b1, "R4 read follows accept", 64'(mem_req_valid), 64'd1);
    exp_addr = entry_addr(model_base, va);
    check(mem_req_addr == exp_addr, "R3 entry address", 64'(mem_req_addr), 64'(exp_addr));
    held_addr = mem_req_addr;
    n = $urandom_range(0, 3);
    if (wr_kind == 1 && n == 0) n = 1;
    for (int i = 0; i < n; i++) begin
      if (wr_kind == 1 && i == 0) begin tbase_we = 1'b1; tbase_wdata = wr_val; end
      @(negedge clk);
      tbase_we = 1'b0;
      check(mem_req_valid && mem_req_addr == held_addr, "R4 read held under stall",
            64'(mem_req_addr), 64'(held_addr));
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    check(mem_req_valid == 1'b0, "R4 single read", 64'(mem_req_valid), 64'd0);
    n = $urandom_range(0, 4);
    for (int i = 0; i < n; i++) @(negedge clk);
    pte = pte_fn(exp_addr, mode);
    mem_rsp_valid = 1'b1; mem_rsp_data = pte;
    @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_data = $urandom;
    check(rsp_valid == 1'b1, "R7 response next cycle", 64'(rsp_valid), 64'd1);
    exp_pa = pte[0] ? {pte[31:12], va[11:0]} : 32'h0;
    if (pte[0]) begin
      check(rsp_fault == 1'b0 && rsp_paddr == exp_pa, "R5 translated address",
            {31'h0, rsp_fault, rsp_paddr}, {32'h0, exp_pa});
    end else begin
      check(rsp_fault == 1'b1 && rsp_paddr == 32'h0, "R6 fault response",
            {31'h0, rsp_fault, rsp_paddr}, {32'h1, 32'h0});
    end
    held_pa = rsp_paddr; held_f = rsp_fault;
    n = $urandom_range(0, 3);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(rsp_valid && rsp_paddr == held_pa && rsp_fault == held_f, "R7 response held",
            64'(rsp_paddr), 64'(held_pa));
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check(req_ready == 1'b1 && rsp_valid == 1'b0, "R2 idle after response",
          64'(req_ready), 64'd1);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 reset req_ready", 64'(req_ready), 64'd1);
    check(rsp_valid == 1'b0, "R1 reset rsp_valid", 64'(rsp_valid), 64'd0);
    check(mem_req_valid == 1'b0, "R1 reset mem_req_valid", 64'(mem_req_valid), 64'd0);

    // directed corners
    set_base(32'h0001_0000);
    translate(32'h0000_0000, 1, 0, 0);
    translate(32'hFFFF_FFFF, 1, 0, 0);
    translate(32'h1234_5ABC, 2, 0, 0);
    // R8: write in flight is dropped, next walk still uses old base
    translate(32'h0004_2010, 1, 1, 32'h00AB_C000);
    translate(32'h0004_2010, 0, 0, 0);
    // R8: write together with request applies to it
    translate(32'h0007_7777, 1, 2, 32'h0020_0000);
    translate(32'h0007_7000, 2, 0, 0);

    for (int t = 0; t < 150; t++) begin
      if ($urandom_range(0, 4) == 0) set_base({$urandom_range(0, 32'hFFFF), 16'h0});
      translate($urandom, $urandom_range(0, 2), $urandom_range(0, 3) == 0 ? 1 : 0,
                {$urandom_range(0, 32'hFFFF), 16'h0});
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule